// File: doc/BRIEF.md
# Flash Chip-Erase Command Interpreter

This block is a synthesizable behavioural model of the command front end of a parallel NOR flash. It watches the asynchronous bus strobes (chip enable, write enable, output enable) together with address and data, carries the strobes into its own clock domain, and decodes the six-write chip-erase sequence: two unlock writes, a setup write, two more unlock writes and a confirm write. Any write that does not match the next expected step drops the interpreter back to array-read mode.

Once the confirm write lands, reads return a status byte instead of array data. A parameterised cycle counter stands in for the erase time, and an input pin decides whether the erase ends in failure. While the erase runs, only the reset and suspend commands are acted on. In array-read mode the output simply passes through the data of an external array model.

States: `ST_READ` (array read), `ST_UNLK1`, `ST_UNLK2` (first two unlock writes seen), `ST_SETUP` (setup seen), `ST_UNLK3`, `ST_UNLK4` (second unlock pair seen), `ST_ERASE` (erase running), `ST_SUSP` (erase suspended), `ST_DONE` (erase finished cleanly), `ST_FAIL` (erase finished with error). Transitions: the unlock chain `ST_READ -> ST_UNLK1 -> ST_UNLK2 -> ST_SETUP -> ST_UNLK3 -> ST_UNLK4 -> ST_ERASE` on matching writes, and from any chain state to `ST_READ` on a mismatch. From `ST_ERASE`: to `ST_SUSP` on suspend, to `ST_DONE` or `ST_FAIL` when the timer expires. From every state: to `ST_READ` on a reset write.

Top module: `nor_cmd_seq`

## Requirements
- R1: With `word_mode`=0 the writes AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h, 10h@AAAh start an erase. With `word_mode`=1 the addresses are 555h, 2AAh, 555h, 555h, 2AAh, 555h in the same order. From the erase onward every read returns the status byte.
- R2: A write whose data or address differs from the expected step of the sequence returns the interpreter to array read. The rest of an aborted sequence then starts no erase, and reads return `arr_rdata`.
- R3: A write takes effect when the overlap of `ce_n` low and `we_n` low ends, whichever of the two rises first. It uses the address and data present at that moment.
- R4: Status byte layout: bit 7 is the done flag, bits 6 and 2 are the toggle bits, bit 5 is the error flag, and all other bits are 0. While erasing, bit 7 reads 0.
- R5: While erasing, bits 6 and 2 invert at the end of each read. The first read after the confirm write shows them as 0.
- R6: The erase lasts exactly `ERASE_CYC` clocks from the clock in which the confirm write is decoded. Afterwards bit 7 reads 1, the toggle bits are frozen, and bit 5 equals `fail_inject` as sampled at completion. Status mode persists until a reset write.
- R7: While erasing, writes other than F0h and B0h are ignored.
- R8: A write of F0h to any address returns to array read from any state.
- R9: A write of B0h while erasing suspends the erase. Reads then show bit 7 = 1, frozen toggle bits and bit 5 = 0, and the timer no longer advances.
- R10: When a suspend write is decoded in the same clock in which the timer expires, the suspend wins.
- R11: After reset the interpreter is in array read, so `dout` equals `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| word_mode | input | 1 | 1 selects the word-mode unlock addresses, 0 the byte-mode ones |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Bus write data |
| fail_inject | input | 1 | Sampled at erase completion; 1 makes the erase fail |
| arr_rdata | input | 8 | Array data returned in read mode |
| dout | output | 8 | Array data or status byte |

## Verification
Timer expiry and a decoded command write can land in the same clock. The bench provokes this by releasing a B0h write exactly `ERASE_CYC` clocks after releasing the confirm write, with `fail_inject` held at 1. A status byte of 80h shows that the suspend won, while A0h would show that completion won. The same release is repeated one clock earlier, which must also give 80h, and one clock later, which must give A0h because the suspend is then ignored. Together these runs pin down both the priority and the exact erase length.

// File: rtl/ncs_pkg.sv
package ncs_pkg;
    localparam int DQ_W = 8;

    typedef enum logic [3:0] {
        ST_READ, ST_UNLK1, ST_UNLK2, ST_SETUP, ST_UNLK3,
        ST_UNLK4, ST_ERASE, ST_SUSP, ST_DONE, ST_FAIL
    } ncs_state_e;

    localparam logic [DQ_W-1:0] CMD_KEY_A   = 8'hAA;
    localparam logic [DQ_W-1:0] CMD_KEY_B   = 8'h55;
    localparam logic [DQ_W-1:0] CMD_SETUP   = 8'h80;
    localparam logic [DQ_W-1:0] CMD_CHIP    = 8'h10;
    localparam logic [DQ_W-1:0] CMD_RESET   = 8'hF0;
    localparam logic [DQ_W-1:0] CMD_SUSPEND = 8'hB0;

    localparam int SB_DONE = 7;
    localparam int SB_TOGA = 6;
    localparam int SB_ERR  = 5;
    localparam int SB_TOGB = 2;
endpackage

// File: rtl/ncs_bus_sync.sv
module ncs_bus_sync #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_evt,
    output logic              rd_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] ce_p, we_p, oe_p;
    logic [ADDR_W-1:0]      a_p [SYNC_STAGES];
    logic [DATA_W-1:0]      d_p [SYNC_STAGES];
    logic                   wr_on, rd_on, wr_on_q, rd_on_q;

    // strobe synchronisers, idle-high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_p <= '1;
            we_p <= '1;
            oe_p <= '1;
        end else begin
            ce_p <= {ce_p[LAST-1:0], ce_n};
            we_p <= {we_p[LAST-1:0], we_n};
            oe_p <= {oe_p[LAST-1:0], oe_n};
        end
    end

    // address/data delayed by the same depth so they line up with the strobes
    always_ff @(posedge clk) begin
        a_p[0] <= addr;
        d_p[0] <= din;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            a_p[i] <= a_p[i-1];
            d_p[i] <= d_p[i-1];
        end
    end

    assign wr_on = ~ce_p[LAST] & ~we_p[LAST];
    assign rd_on = ~ce_p[LAST] & ~oe_p[LAST] & we_p[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_on_q <= 1'b0;
            rd_on_q <= 1'b0;
        end else begin
            wr_on_q <= wr_on;
            rd_on_q <= rd_on;
        end
    end

    assign wr_evt  = wr_on_q & ~wr_on;
    assign rd_end  = rd_on_q & ~rd_on;
    assign wr_addr = a_p[LAST];
    assign wr_data = d_p[LAST];
endmodule

// File: rtl/ncs_erase_timer.sv
module ncs_erase_timer #(
    parameter int ERASE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (run && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CNT_LAST);
endmodule

// File: rtl/ncs_cmd_fsm.sv
module ncs_cmd_fsm
    import ncs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              rd_end,
    input  logic              word_mode,
    input  logic              tim_done,
    input  logic              fail_inject,
    input  logic [DQ_W-1:0]   arr_rdata,
    output ncs_state_e        state,
    output logic              tim_start,
    output logic              tim_run,
    output logic [DQ_W-1:0]   dout
);
    localparam logic [ADDR_W-1:0] BYTE_ADR_A = ADDR_W'(12'hAAA);
    localparam logic [ADDR_W-1:0] BYTE_ADR_B = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] WORD_ADR_A = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] WORD_ADR_B = ADDR_W'(12'h2AA);

    ncs_state_e        state_nx;
    logic              hit_a, hit_b, tog;
    logic [DQ_W-1:0]   stat;

    assign hit_a = wr_addr == (word_mode ? WORD_ADR_A : BYTE_ADR_A);
    assign hit_b = wr_addr == (word_mode ? WORD_ADR_B : BYTE_ADR_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_READ;
        else
            state <= state_nx;
    end

    // next-state decode; commands outrank timer expiry
    always_comb begin
        state_nx = state;
        if (wr_evt && wr_data == CMD_RESET) begin
            state_nx = ST_READ;
        end else if (wr_evt) begin
            unique case (state)
                ST_READ:  if (wr_data == CMD_KEY_A && hit_a) state_nx = ST_UNLK1;
                ST_UNLK1: state_nx = (wr_data == CMD_KEY_B && hit_b) ? ST_UNLK2 : ST_READ;
                ST_UNLK2: state_nx = (wr_data == CMD_SETUP && hit_a) ? ST_SETUP : ST_READ;
                ST_SETUP: state_nx = (wr_data == CMD_KEY_A && hit_a) ? ST_UNLK3 : ST_READ;
                ST_UNLK3: state_nx = (wr_data == CMD_KEY_B && hit_b) ? ST_UNLK4 : ST_READ;
                ST_UNLK4: state_nx = (wr_data == CMD_CHIP && hit_a) ? ST_ERASE : ST_READ;
                ST_ERASE: begin
                    if (wr_data == CMD_SUSPEND)
                        state_nx = ST_SUSP;
                    else if (tim_done)
                        state_nx = fail_inject ? ST_FAIL : ST_DONE;
                end
                ST_SUSP, ST_DONE, ST_FAIL: state_nx = state;
                default:  state_nx = ST_READ;
            endcase
        end else if (state == ST_ERASE && tim_done) begin
            state_nx = fail_inject ? ST_FAIL : ST_DONE;
        end
    end

    assign tim_start = wr_evt && state == ST_UNLK4 && wr_data == CMD_CHIP && hit_a;
    assign tim_run   = state == ST_ERASE;

    // toggle bit: flips at the end of every read while erasing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (tim_start)
            tog <= 1'b0;
        else if (state == ST_ERASE && rd_end)
            tog <= ~tog;
    end

    // output process
    always_comb begin
        stat          = '0;
        stat[SB_DONE] = state != ST_ERASE;
        stat[SB_TOGA] = tog;
        stat[SB_TOGB] = tog;
        stat[SB_ERR]  = state == ST_FAIL;
        unique case (state)
            ST_ERASE, ST_SUSP, ST_DONE, ST_FAIL: dout = stat;
            default:                              dout = arr_rdata;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import ncs_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int ERASE_CYC   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              fail_inject,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        dout
);
    logic              wr_evt, rd_end, tim_start, tim_run, tim_done;
    logic [ADDR_W-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;
    ncs_state_e        state;

    ncs_bus_sync #(
        .ADDR_W(ADDR_W), .DATA_W(DQ_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_evt(wr_evt), .rd_end(rd_end),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ncs_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tim_start), .run(tim_run), .done(tim_done)
    );

    ncs_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_end(rd_end), .word_mode(word_mode),
        .tim_done(tim_done), .fail_inject(fail_inject), .arr_rdata(arr_rdata),
        .state(state), .tim_start(tim_start), .tim_run(tim_run), .dout(dout)
    );
endmodule

// File: rtl/ncs_checker.sv
module ncs_checker
    import ncs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input ncs_state_e state,
    input logic       wr_evt,
    input logic [7:0] wr_data,
    input logic       rd_end,
    input logic       tim_done,
    input logic       fail_inject,
    input logic [7:0] dout
);
    p_erase_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_ERASE) |-> $past(state == ST_UNLK4 && wr_evt && wr_data == CMD_CHIP));

    p_busy_dq7_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ERASE |-> !dout[SB_DONE]);

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && rd_end && !wr_evt) |=> dout[SB_TOGA] != $past(dout[SB_TOGA]));

    p_fail_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_FAIL) |-> $past(fail_inject && tim_done));

    p_timer_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tim_done |-> state == ST_ERASE);

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && wr_evt && wr_data != CMD_RESET && wr_data != CMD_SUSPEND && !tim_done)
        |=> state == ST_ERASE);

    p_reset_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && wr_data == CMD_RESET) |=> state == ST_READ);

    p_suspend_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && wr_evt && wr_data == CMD_SUSPEND) |=> state == ST_SUSP);
endmodule

bind nor_cmd_seq ncs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_evt(wr_evt), .wr_data(wr_data),
    .rd_end(rd_end), .tim_done(tim_done), .fail_inject(fail_inject), .dout(dout)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
    localparam int EC = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        word_mode = 1'b0, fail_inject = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  din = '0, arr_rdata = 8'h5A;
    logic [7:0]  dout;

    int n_chk = 0, n_fail = 0, ncyc = 0, last_rel = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       smp_ev;

    always #5 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;

    nor_cmd_seq #(.ADDR_W(12), .ERASE_CYC(EC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .addr(addr), .din(din), .fail_inject(fail_inject),
        .arr_rdata(arr_rdata), .dout(dout)
    );

    // monitor: pops expected items and compares against the output
    initial forever begin
        @(smp_ev);
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (dout !== e) begin
                n_fail++;
                $display("FAIL %s: dout=%02h expected %02h", t, dout, e);
            end
        end
    end

    task automatic push_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> smp_ev;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; last_rel = ncyc;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_ce(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; we_n = 1'b0;
        @(negedge clk); ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; last_rel = ncyc;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_at(input logic [11:0] a, input logic [7:0] d, input int target);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        while (ncyc < target) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] e, input string t);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        push_exp(e, t);
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic chip_erase(input bit use_ce);
        logic [11:0] a, b;
        a = word_mode ? 12'h555 : 12'hAAA;
        b = word_mode ? 12'h2AA : 12'h555;
        if (use_ce) begin
            wr_ce(a, 8'hAA); wr_ce(b, 8'h55); wr_ce(a, 8'h80);
            wr_ce(a, 8'hAA); wr_ce(b, 8'h55); wr_ce(a, 8'h10);
        end else begin
            wr(a, 8'hAA); wr(b, 8'h55); wr(a, 8'h80);
            wr(a, 8'hAA); wr(b, 8'h55); wr(a, 8'h10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push_exp(8'h5A, "R11 reset passes array data");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h5A, "R11 read mode after reset");

        // R1/R4/R5/R7/R6: byte-mode erase, clean finish
        chip_erase(0);
        rd(8'h00, "R4 busy status, first read R5");
        wr(12'hAAA, 8'hAA);
        wr(12'h555, 8'h10);
        rd(8'h44, "R5 toggle after one read, R7 writes ignored");
        rd(8'h00, "R5 toggle back");
        repeat (EC + 30) @(negedge clk);
        rd(8'hC4, "R6 done, toggle frozen");
        rd(8'hC4, "R6 toggle stays frozen");
        wr(12'h123, 8'hF0);
        arr_rdata = 8'h3C;
        rd(8'h3C, "R8 reset write returns to array read");

        // R2: aborted sequences
        wr(12'hAAA, 8'hAA); wr(12'h2AA, 8'h55); wr(12'hAAA, 8'h80);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h10);
        rd(8'h3C, "R2 wrong address cycle 2");
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h90);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h10);
        rd(8'h3C, "R2 wrong setup data");
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h80);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h30);
        rd(8'h3C, "R2 wrong confirm data");
        word_mode = 1'b1;
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h80);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h10);
        rd(8'h3C, "R2 byte addresses in word mode");
        word_mode = 1'b0;
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'h000, 8'hF0);
        wr(12'hAAA, 8'h80); wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, 8'h10);
        rd(8'h3C, "R8 reset mid sequence");

        // R3: chip-enable-controlled writes, word mode, failing erase
        word_mode = 1'b1; fail_inject = 1'b1;
        chip_erase(1);
        repeat (EC + 30) @(negedge clk);
        rd(8'hA0, "R3 ce-controlled sequence, R6 error flag");
        wr(12'h555, 8'hAA);
        rd(8'hA0, "R6 failure held until reset");
        wr(12'h000, 8'hF0);
        rd(8'h3C, "R8 reset clears failure");

        // R9: suspend
        word_mode = 1'b0;
        chip_erase(0);
        rd(8'h00, "R9 busy before suspend");
        rd(8'h44, "R9 toggling before suspend");
        wr(12'h000, 8'hB0);
        rd(8'h80, "R9 suspended status");
        rd(8'h80, "R9 toggle frozen in suspend");
        repeat (EC + 30) @(negedge clk);
        rd(8'h80, "R9 timer halted, no error");
        wr(12'h000, 8'hF0);
        rd(8'h3C, "R8 reset from suspend");

        // R10: suspend decoded in the completion clock
        chip_erase(0);
        wr_at(12'h000, 8'hB0, last_rel + EC);
        rd(8'h80, "R10 suspend wins over completion");
        wr(12'h000, 8'hF0);
        chip_erase(0);
        wr_at(12'h000, 8'hB0, last_rel + EC - 1);
        rd(8'h80, "R6 suspend one clock before completion");
        wr(12'h000, 8'hF0);
        chip_erase(0);
        wr_at(12'h000, 8'hB0, last_rel + EC + 1);
        rd(8'hA0, "R6 suspend one clock after completion ignored");
        wr(12'h000, 8'hF0);
        rd(8'h3C, "R8 final reset");

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule